// File: doc/BRIEF.md
# 8-bit ALU with Flag and Pointer-Mode Status Register

This block is the arithmetic and logic datapath of a small 8-bit processor core, together with the status register that records its condition flags. Every operation takes the working register as operand A. Operand B is either a file-register value or an 8-bit immediate. Depending on the operation, operand B may be the only operand used. The block computes the result combinationally. On a clock edge with the write enable set, it updates the zero, digit-carry, carry and overflow flags held in the status register.

The upper half of the status register holds two 2-bit fields. Each field chooses what an indirect address pointer does after an access: step down, step up or hold. The block decodes each field into per-pointer step-up and step-down strobes. The pointer registers themselves live elsewhere.

The status register is also an ordinary write destination. When an operation that affects flags names it as the destination, the ALU-computed flags win over the written data in the low four bits. The upper four bits still take the written result. Subtraction produces carry and digit carry as inverted borrows.

Top module: `alu8_status_unit`

## Requirements
- R1: While reset is asserted and after its release, status_o reads 8'hF0: both mode fields are 2'b11 and the flags OV (bit 3), Z (bit 2), DC (bit 1) and C (bit 0) are 0. ptr_inc_o and ptr_dec_o are 0.
- R2: Add (op_i = 0) outputs opa_i + opb_i. C is the carry out of bit 7, DC is the carry out of bit 3, OV is set when the two operands share a sign that the result does not have, and Z is set when the result is zero.
- R3: Subtract (op_i = 1) outputs opb_i - opa_i, computed as opb_i + ~opa_i + 1. C = 1 means no borrow from bit 7, DC = 1 means no borrow from bit 3, and OV and Z are as for add.
- R4: AND, OR and XOR (op_i = 2, 3, 4) output the bitwise result of the two operands. They update Z only and leave C, DC and OV unchanged.
- R5: Rotate right through carry (op_i = 5) outputs {C, opb_i[7:1]} and loads C with opb_i[0]. Rotate left (op_i = 6) outputs {opb_i[6:0], C} and loads C with opb_i[7]. Z, DC and OV are unchanged.
- R6: Clear (op_i = 7) outputs 0 and sets Z, leaving OV, DC and C unchanged. With the status register as destination, it leaves the upper four bits at 0.
- R7: Swap nibbles (op_i = 8), bit set (op_i = 9), bit clear (op_i = 10, bit index bit_sel_i) and move working register (op_i = 11, result = opa_i) change no flag. With the status register as destination, all eight bits take the result.
- R8: When a flag-affecting operation writes to the status register, bits 7:4 take result bits 7:4. The low four bits ignore the written data: affected flags take the ALU values and the others keep their old values.
- R9: With wr_en_i low, status_o does not change, and result_o still shows the combinational result.
- R10: Mode field bits 5:4 control pointer 0 and bits 7:6 control pointer 1. Code 2'b00 raises ptr_dec_o[i], 2'b01 raises ptr_inc_o[i], and 2'b1x raises neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation select (codes in R2 to R7; other codes pass opb_i, no flags) |
| opa_i | input | 8 | Working register operand |
| opb_i | input | 8 | File register value or immediate |
| bit_sel_i | input | 3 | Bit index for bit set and bit clear |
| wr_en_i | input | 1 | Commit the operation on this clock edge |
| dst_status_i | input | 1 | Result destination is the status register |
| result_o | output | 8 | Combinational operation result |
| status_o | output | 8 | Status register contents |
| ptr_inc_o | output | 2 | Per-pointer post-increment select |
| ptr_dec_o | output | 2 | Per-pointer post-decrement select |

## Verification
Addition is driven with operand pairs chosen so that each flag fires on its own. A carry out of the low nibble alone tests DC without C. Two negative operands summing to zero test C, Z and OV together. A positive sum crossing into the sign bit tests OV without C. Subtraction is driven with pairs that borrow, pairs that do not, a zero difference, and a negative minus positive that overflows, which separates the inverted-borrow carries from OV. Logic, rotate and clear operations follow one another so that each leaves flags set by the previous operation visible, showing which flags each one may touch. Status-destination writes with flag-affecting and flag-neutral operations then show whether the written low nibble is blocked or accepted.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_RRC  = 4'd5,
    OP_RLC  = 4'd6,
    OP_CLR  = 4'd7,
    OP_SWAP = 4'd8,
    OP_BSET = 4'd9,
    OP_BCLR = 4'd10,
    OP_MOVW = 4'd11,
    OP_PASS = 4'd12
  } alu_op_e;

  localparam int OP_W      = 4;
  localparam int STAT_W    = 8;
  localparam int FLAG_W    = 4;
  localparam int FLAG_C    = 0;
  localparam int FLAG_DC   = 1;
  localparam int FLAG_Z    = 2;
  localparam int FLAG_OV   = 3;
  localparam int NUM_PTR   = 2;
  localparam int MODE_W    = 2;
  localparam int MODE_LSB  = FLAG_W;
  localparam logic [STAT_W-1:0] STAT_RESET = 8'hF0;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              hcout_o,
  output logic              ovf_o
);

  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0] full_sum;
  logic [NIB_W:0]  low_sum;

  always_comb begin
    full_sum = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
    low_sum  = {1'b0, x_i[NIB_W-1:0]} + {1'b0, y_i[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, cin_i};
    sum_o    = full_sum[DATA_W-1:0];
    cout_o   = full_sum[DATA_W];
    hcout_o  = low_sum[NIB_W];
    ovf_o    = (x_i[DATA_W-1] == y_i[DATA_W-1]) &&
               (full_sum[DATA_W-1] != x_i[DATA_W-1]);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]          op_i,
  input  logic [DATA_W-1:0]        opa_i,
  input  logic [DATA_W-1:0]        opb_i,
  input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
  input  logic                     carry_i,
  output logic [DATA_W-1:0]        result_o,
  output logic [FLAG_W-1:0]        flag_we_o,
  output logic [FLAG_W-1:0]        flag_val_o
);

  localparam int NIB_W = DATA_W / 2;

  alu_op_e           op_e;
  logic              is_sub;
  logic [DATA_W-1:0] add_y;
  logic [DATA_W-1:0] add_sum;
  logic              add_c;
  logic              add_h;
  logic              add_v;
  logic [DATA_W-1:0] bit_mask;

  assign op_e     = alu_op_e'(op_i);
  assign is_sub   = (op_e == OP_SUB);
  assign add_y    = is_sub ? ~opa_i : opa_i;
  assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel_i;

  alu8_adder #(.DATA_W(DATA_W)) adder_i (
    .x_i    (opb_i),
    .y_i    (add_y),
    .cin_i  (is_sub),
    .sum_o  (add_sum),
    .cout_o (add_c),
    .hcout_o(add_h),
    .ovf_o  (add_v)
  );

  always_comb begin
    result_o   = opb_i;
    flag_we_o  = '0;
    flag_val_o = '0;
    case (op_e)
      OP_ADD, OP_SUB: begin
        result_o            = add_sum;
        flag_we_o           = '1;
        flag_val_o[FLAG_C]  = add_c;
        flag_val_o[FLAG_DC] = add_h;
        flag_val_o[FLAG_OV] = add_v;
      end
      OP_AND: begin
        result_o          = opa_i & opb_i;
        flag_we_o[FLAG_Z] = 1'b1;
      end
      OP_OR: begin
        result_o          = opa_i | opb_i;
        flag_we_o[FLAG_Z] = 1'b1;
      end
      OP_XOR: begin
        result_o          = opa_i ^ opb_i;
        flag_we_o[FLAG_Z] = 1'b1;
      end
      OP_RRC: begin
        result_o           = {carry_i, opb_i[DATA_W-1:1]};
        flag_we_o[FLAG_C]  = 1'b1;
        flag_val_o[FLAG_C] = opb_i[0];
      end
      OP_RLC: begin
        result_o           = {opb_i[DATA_W-2:0], carry_i};
        flag_we_o[FLAG_C]  = 1'b1;
        flag_val_o[FLAG_C] = opb_i[DATA_W-1];
      end
      OP_CLR: begin
        result_o          = '0;
        flag_we_o[FLAG_Z] = 1'b1;
      end
      OP_SWAP: result_o = {opb_i[NIB_W-1:0], opb_i[DATA_W-1:NIB_W]};
      OP_BSET: result_o = opb_i | bit_mask;
      OP_BCLR: result_o = opb_i & ~bit_mask;
      OP_MOVW: result_o = opa_i;
      default: result_o = opb_i;
    endcase
    flag_val_o[FLAG_Z] = ~|result_o;
  end

  // R6: clear yields zero and reports Z set
  always_comb begin
    if (op_e == OP_CLR) begin
      a_r6_clear_zero: assert (result_o == '0 && flag_val_o[FLAG_Z]);
    end
  end

  // R7: flag-neutral operations request no flag update
  always_comb begin
    if (op_e == OP_SWAP || op_e == OP_BSET || op_e == OP_BCLR || op_e == OP_MOVW) begin
      a_r7_neutral_no_flags: assert (flag_we_o == '0);
    end
  end

endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              dst_status_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] flag_we_i,
  input  logic [FLAG_W-1:0] flag_val_i,
  output logic [STAT_W-1:0] status_o
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_d;
  logic [FLAG_W-1:0] flag_merge;
  logic              flag_op;

  assign flag_op    = |flag_we_i;
  assign flag_merge = (flag_we_i & flag_val_i) | (~flag_we_i & stat_q[FLAG_W-1:0]);

  always_comb begin
    stat_d = stat_q;
    if (wr_en_i) begin
      if (dst_status_i) begin
        stat_d[STAT_W-1:FLAG_W] = wdata_i[STAT_W-1:FLAG_W];
      end
      if (dst_status_i && !flag_op) begin
        stat_d[FLAG_W-1:0] = wdata_i[FLAG_W-1:0];
      end else begin
        stat_d[FLAG_W-1:0] = flag_merge;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
    end else if (wr_en_i) begin
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  // R9: no commit, no change
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(status_o));

  // R8: flag-affecting write to status: upper half from data, unaffected flags kept
  a_r8_upper_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && dst_status_i && flag_op) |=>
      (status_o[STAT_W-1:FLAG_W] == $past(wdata_i[STAT_W-1:FLAG_W])));

  a_r4_untouched_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (!dst_status_i || flag_op)) |=>
      ((status_o[FLAG_W-1:0] & ~$past(flag_we_i)) ==
       ($past(status_o[FLAG_W-1:0]) & ~$past(flag_we_i))));

  // R7: flag-neutral write to status copies the whole byte
  a_r7_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && dst_status_i && !flag_op) |=> (status_o == $past(wdata_i)));

endmodule

// File: rtl/alu8_ptr_mode.sv
module alu8_ptr_mode
  import alu8_pkg::*;
(
  input  logic [STAT_W-1:0]  status_i,
  output logic [NUM_PTR-1:0] inc_o,
  output logic [NUM_PTR-1:0] dec_o
);

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic [MODE_W-1:0] mode;
    assign mode     = status_i[MODE_LSB + p*MODE_W +: MODE_W];
    assign inc_o[p] = (mode == 2'b01);
    assign dec_o[p] = (mode == 2'b00);

    // R10: a pointer never steps both ways
    always_comb begin
      a_r10_one_direction: assert ($onehot0({inc_o[p], dec_o[p]}));
    end
  end

endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                op_i,
  input  logic [DATA_W-1:0]         opa_i,
  input  logic [DATA_W-1:0]         opb_i,
  input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
  input  logic                      wr_en_i,
  input  logic                      dst_status_i,
  output logic [DATA_W-1:0]         result_o,
  output logic [STAT_W-1:0]         status_o,
  output logic [NUM_PTR-1:0]        ptr_inc_o,
  output logic [NUM_PTR-1:0]        ptr_dec_o
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [FLAG_W-1:0] flag_we;
  logic [FLAG_W-1:0] flag_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  alu8_core #(.DATA_W(DATA_W)) core_i (
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .bit_sel_i (bit_sel_i),
    .carry_i   (status_o[FLAG_C]),
    .result_o  (result_o),
    .flag_we_o (flag_we),
    .flag_val_o(flag_val)
  );

  alu8_status_reg stat_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en_i     (wr_en_i),
    .dst_status_i(dst_status_i),
    .wdata_i     (result_o[STAT_W-1:0]),
    .flag_we_i   (flag_we),
    .flag_val_i  (flag_val),
    .status_o    (status_o)
  );

  alu8_ptr_mode ptr_i (
    .status_i(status_o),
    .inc_o   (ptr_inc_o),
    .dec_o   (ptr_dec_o)
  );

  // R5: rotate loads carry with the bit shifted out
  a_r5_rotate_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && !dst_status_i && op_i == 4'd5) |=>
      (status_o[FLAG_C] == $past(opb_i[0])));

  // R3: zero difference means no borrow
  a_r3_equal_no_borrow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && !dst_status_i && op_i == 4'd1 && opa_i == opb_i) |=>
      (status_o[FLAG_C] && status_o[FLAG_DC] && status_o[FLAG_Z]));

endmodule

// File: tb/alu8_status_unit_tb.sv
module alu8_status_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] opa_i = '0;
  logic [7:0] opb_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic       wr_en_i = 1'b0;
  logic       dst_status_i = 1'b0;
  logic [7:0] result_o;
  logic [7:0] status_o;
  logic [1:0] ptr_inc_o;
  logic [1:0] ptr_dec_o;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  logic [7:0] got_res;
  logic [7:0] got_stat;

  always #4 clk = ~clk;

  alu8_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .bit_sel_i(bit_sel_i), .wr_en_i(wr_en_i), .dst_status_i(dst_status_i),
    .result_o(result_o), .status_o(status_o),
    .ptr_inc_o(ptr_inc_o), .ptr_dec_o(ptr_dec_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] bs, input logic we, input logic dst);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; bit_sel_i = bs; wr_en_i = we; dst_status_i = dst;
    #1;
    got_res = result_o;
    @(posedge clk);
    #1;
    got_stat = status_o;
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic [2:0] bs, input logic dst,
                     input logic [7:0] exp_res, input logic [7:0] exp_stat);
    step(op, a, b, bs, 1'b1, dst);
    chk({tag, " result"}, got_res, exp_res);
    chk({tag, " status"}, got_stat, exp_stat);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", status_o, 8'hF0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 status after release", status_o, 8'hF0);
    chk("R1 pointer strobes", {4'h0, ptr_inc_o, ptr_dec_o}, 8'h00);
  endtask

  task automatic t_add();
    run("R2 nibble carry",     4'd0, 8'h0F, 8'h01, 3'd0, 1'b0, 8'h10, 8'hF2);
    run("R2 carry zero ovf",   4'd0, 8'h80, 8'h80, 3'd0, 1'b0, 8'h00, 8'hFD);
    run("R2 positive ovf",     4'd0, 8'h7F, 8'h01, 3'd0, 1'b0, 8'h80, 8'hFA);
  endtask

  task automatic t_sub();
    run("R3 no borrow",        4'd1, 8'h01, 8'h05, 3'd0, 1'b0, 8'h04, 8'hF3);
    run("R3 borrow",           4'd1, 8'h01, 8'h00, 3'd0, 1'b0, 8'hFF, 8'hF0);
    run("R3 equal",            4'd1, 8'h05, 8'h05, 3'd0, 1'b0, 8'h00, 8'hF7);
    run("R3 signed ovf",       4'd1, 8'h01, 8'h80, 3'd0, 1'b0, 8'h7F, 8'hF9);
  endtask

  task automatic t_logic();
    run("R4 and zero",         4'd2, 8'hF0, 8'h0F, 3'd0, 1'b0, 8'h00, 8'hFD);
    run("R4 or nonzero",       4'd3, 8'h01, 8'h00, 3'd0, 1'b0, 8'h01, 8'hF9);
    run("R4 xor zero",         4'd4, 8'hAA, 8'hAA, 3'd0, 1'b0, 8'h00, 8'hFD);
  endtask

  task automatic t_rotate();
    run("R5 rrc",              4'd5, 8'h00, 8'h02, 3'd0, 1'b0, 8'h81, 8'hFC);
    run("R5 rlc out one",      4'd6, 8'h00, 8'h80, 3'd0, 1'b0, 8'h00, 8'hFD);
    run("R5 rlc in one",       4'd6, 8'h00, 8'h01, 3'd0, 1'b0, 8'h03, 8'hFC);
  endtask

  task automatic t_clear();
    run("R6 prep or",          4'd3, 8'h01, 8'h00, 3'd0, 1'b0, 8'h01, 8'hF8);
    run("R6 clear",            4'd7, 8'h33, 8'h44, 3'd0, 1'b0, 8'h00, 8'hFC);
    run("R6 clear status dst", 4'd7, 8'h33, 8'h44, 3'd0, 1'b1, 8'h00, 8'h0C);
  endtask

  task automatic t_noflag();
    run("R7 movw to status",   4'd11, 8'h5A, 8'h00, 3'd0, 1'b1, 8'h5A, 8'h5A);
    run("R7 swap to status",   4'd8,  8'h00, 8'h3C, 3'd0, 1'b1, 8'hC3, 8'hC3);
    run("R7 bit set",          4'd9,  8'h00, 8'h00, 3'd7, 1'b0, 8'h80, 8'hC3);
    run("R7 bit clear",        4'd10, 8'h00, 8'hFF, 3'd0, 1'b0, 8'hFE, 8'hC3);
    run("R7 bit set status",   4'd9,  8'h00, 8'hC3, 3'd2, 1'b1, 8'hC7, 8'hC7);
  endtask

  task automatic t_blocked();
    run("R8 add to status",    4'd0, 8'h13, 8'h25, 3'd0, 1'b1, 8'h38, 8'h30);
    chk("R10 inc after 30", {6'h0, ptr_inc_o}, 8'h00);
    chk("R10 dec after 30", {6'h0, ptr_dec_o}, 8'h02);
  endtask

  task automatic t_idle();
    step(4'd0, 8'h80, 8'h80, 3'd0, 1'b0, 1'b1);
    chk("R9 result still shown", got_res, 8'h00);
    chk("R9 status held", got_stat, 8'h30);
  endtask

  task automatic t_modes();
    run("R10 write 50", 4'd11, 8'h50, 8'h00, 3'd0, 1'b1, 8'h50, 8'h50);
    chk("R10 inc both", {6'h0, ptr_inc_o}, 8'h03);
    chk("R10 dec none", {6'h0, ptr_dec_o}, 8'h00);
    run("R10 write 60", 4'd11, 8'h60, 8'h00, 3'd0, 1'b1, 8'h60, 8'h60);
    chk("R10 inc p1 only", {6'h0, ptr_inc_o}, 8'h02);
    chk("R10 dec none hold", {6'h0, ptr_dec_o}, 8'h00);
    run("R10 write 10", 4'd11, 8'h10, 8'h00, 3'd0, 1'b1, 8'h10, 8'h10);
    chk("R10 inc p0", {6'h0, ptr_inc_o}, 8'h01);
    chk("R10 dec p1", {6'h0, ptr_dec_o}, 8'h02);
    run("R10 write B0", 4'd11, 8'hB0, 8'h00, 3'd0, 1'b1, 8'hB0, 8'hB0);
    chk("R10 hold both", {4'h0, ptr_inc_o, ptr_dec_o}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_clear();
    t_noflag();
    t_blocked();
    t_idle();
    t_modes();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule